// File: doc/BRIEF.md
# Carry-Select Adder with Excess-One Incrementer

This block is a purely combinational binary adder. It splits its operands into equal groups of bits. The lowest group is an ordinary ripple-carry adder that takes the external carry-in. Each higher group builds only one sum, with a ripple-carry adder whose carry-in is tied to zero. A small incrementer made of XOR, AND and inverter gates turns that sum, and its carry, into the version that a carry-in of one would give. A two-way selector then picks one of the two results, steered by the carry that arrives from the group below. The selected carry of each group steers the group above it.

Compared with a classic carry-select adder, the second adder in each upper group is replaced by the incrementer. The delay keeps its select-chain shape and the duplicate adder is gone. Width and group size are parameters; the default is a 16-bit adder in 4-bit groups. The block is meant to sit inside wider arithmetic datapaths, such as the partial-product summation of a multiplier.

Top module: `csa_bec_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `op_a + op_b + carry_in`, for every operand pair and both carry-in values.
- R2: `carry_out` equals bit WIDTH of `op_a + op_b + carry_in`, that is, it is 1 exactly when the true total reaches 2^WIDTH.
- R3: The lowest group consumes `carry_in` directly: with both operands zero, `sum` equals `carry_in` (0x0001 when it is 1) and `carry_out` is 0.
- R4: A carry produced in the lowest group propagates through every higher group: 0xFFFF + 0x0001 with carry-in 0 gives `sum` 0x0000 and `carry_out` 1.
- R5: A carry-in alone can ripple through all groups: 0xFFFF + 0x0000 with carry-in 1 gives `sum` 0x0000 and `carry_out` 1.
- R6: For each upper group, the carry it passes on equals the carry of that group's operand slices plus the carry arriving from the group below. When that incoming carry is 1, the group's sum is its zero-carry sum plus one, wrapping from all ones to zero with a carry out of 1.
- R7: The arithmetic of R1 and R2 holds for any WIDTH that is a whole multiple of GRP, including group counts other than four and group sizes other than four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The bench builds three copies of the adder. The first uses the default 16-bit width with 4-bit groups. A second uses 8 bits with 4-bit groups, and a third uses 6 bits with 2-bit groups. The two small copies are swept exhaustively over every operand pair and both carry-in values. That reaches every select and increment combination of every group, including the all-ones wrap of each incrementer. The 16-bit copy gets all pairs from a set of boundary patterns: group-aligned all-ones slices, single set bits and sign-bit values. Long carry chains through all four groups fall inside this set. It then gets random operands, with the expected results taken from plain integer addition.

// File: rtl/csa_pkg.sv
// Package: shared helpers for the carry-select adder.
// Assumes widths are positive and width is a whole multiple of group size.
package csa_pkg;

    // Number of groups a width splits into.
    function automatic int group_count(input int width, input int grp);
        return width / grp;
    endfunction

    // True when the width splits into whole groups.
    function automatic bit split_ok(input int width, input int grp);
        return (grp > 0) && (width >= grp) && ((width % grp) == 0);
    endfunction

endpackage

// File: rtl/csa_rca_group.sv
// Module: csa_rca_group
// Ripple-carry adder over one group of GRP bits. Each full adder hands its
// carry-out to the carry-in of the next one up.
// Assumes GRP >= 1. Purely combinational.
module csa_rca_group #(
    parameter int GRP = 4
) (
    input  logic [GRP-1:0] x,
    input  logic [GRP-1:0] y,
    input  logic           cin,
    output logic [GRP-1:0] s,
    output logic           cout
);

    logic [GRP:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < GRP; i++) begin : g_fa
        // Full adder at bit i: sum bit and carry to bit i+1.
        assign s[i]   = x[i] ^ y[i] ^ c[i];
        assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
    end

    assign cout = c[GRP];

endmodule

// File: rtl/csa_excess1.sv
// Module: csa_excess1
// Adds one to a GRP-bit value and its carry bit, using only XOR, AND and
// inverters. Bit i flips when all bits below it are ones. The carry flips
// when the whole value is ones.
// Assumes GRP >= 1. Purely combinational.
module csa_excess1 #(
    parameter int GRP = 4
) (
    input  logic [GRP-1:0] val,
    input  logic           cy,
    output logic [GRP-1:0] val_inc,
    output logic           cy_inc
);

    // run[i] is 1 when val[i-1:0] is all ones; run[0] is the empty product.
    logic [GRP:0] run;

    assign run[0] = 1'b1;

    for (genvar i = 0; i < GRP; i++) begin : g_bit
        // Running AND of the lower bits.
        assign run[i+1] = run[i] & val[i];
        if (i == 0) begin : g_lsb
            // The lowest bit always toggles.
            assign val_inc[i] = ~val[i];
        end else begin : g_upper
            // Toggle when every lower bit is one.
            assign val_inc[i] = val[i] ^ run[i];
        end
    end

    // The carry toggles when the whole group is ones.
    assign cy_inc = cy ^ run[GRP];

endmodule

// File: rtl/csa_sel_mux.sv
// Module: csa_sel_mux
// Two-way selector for a group result: the carry together with the sum bits.
// Assumes W >= 1. Purely combinational.
module csa_sel_mux #(
    parameter int W = 5
) (
    input  logic         sel,
    input  logic [W-1:0] d0,
    input  logic [W-1:0] d1,
    output logic [W-1:0] q
);

    // Pass d1 when the incoming carry is set, else d0.
    always_comb begin
        q = sel ? d1 : d0;
    end

endmodule

// File: rtl/csa_bec_adder.sv
// Module: csa_bec_adder
// WIDTH-bit carry-select adder in GRP-bit groups. Group 0 ripples from
// carry_in. Each higher group ripples with a zero carry. An excess-one
// incrementer forms the one-carry variant, and the carry from the group
// below picks between the two.
// Assumes WIDTH is a whole multiple of GRP. Purely combinational, no clock
// and no reset.
module csa_bec_adder #(
    parameter int WIDTH = 16,
    parameter int GRP   = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    localparam int NGRP = csa_pkg::group_count(WIDTH, GRP);

    // grp_carry[g] is the carry into group g; grp_carry[NGRP] leaves the adder.
    logic [NGRP:0] grp_carry;

    assign grp_carry[0] = carry_in;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = g * GRP;

        if (g == 0) begin : g_base
            // Lowest group: plain ripple from the external carry.
            csa_rca_group #(.GRP(GRP)) rca_i (
                .x    (op_a[LO +: GRP]),
                .y    (op_b[LO +: GRP]),
                .cin  (grp_carry[0]),
                .s    (sum[LO +: GRP]),
                .cout (grp_carry[1])
            );
        end else begin : g_sel
            logic [GRP-1:0] s_zero;
            logic [GRP-1:0] s_one;
            logic           c_zero;
            logic           c_one;
            logic [GRP:0]   picked;

            // Zero-carry sum of this group.
            csa_rca_group #(.GRP(GRP)) rca_i (
                .x    (op_a[LO +: GRP]),
                .y    (op_b[LO +: GRP]),
                .cin  (1'b0),
                .s    (s_zero),
                .cout (c_zero)
            );

            // One-carry sum, derived by incrementing.
            csa_excess1 #(.GRP(GRP)) inc_i (
                .val     (s_zero),
                .cy      (c_zero),
                .val_inc (s_one),
                .cy_inc  (c_one)
            );

            // Carry from below picks the result.
            csa_sel_mux #(.W(GRP + 1)) mux_i (
                .sel (grp_carry[g]),
                .d0  ({c_zero, s_zero}),
                .d1  ({c_one, s_one}),
                .q   (picked)
            );

            assign sum[LO +: GRP]  = picked[GRP-1:0];
            assign grp_carry[g+1]  = picked[GRP];
        end
    end

    assign carry_out = grp_carry[NGRP];

endmodule

// File: rtl/csa_bec_adder_chk.sv
// Module: csa_bec_adder_chk
// Checker bound to csa_bec_adder. It compares the ports and the group carry
// chain against integer addition. It uses immediate assertions, because the
// block has no clock.
module csa_bec_adder_chk #(
    parameter int WIDTH = 16,
    parameter int GRP   = 4
) (
    input logic [WIDTH-1:0]      op_a,
    input logic [WIDTH-1:0]      op_b,
    input logic                  carry_in,
    input logic [WIDTH-1:0]      sum,
    input logic                  carry_out,
    input logic [WIDTH/GRP:0]    grp_carry
);

    localparam int NGRP = WIDTH / GRP;

    logic [WIDTH:0] total;

    // Reference total from integer addition.
    always_comb begin
        total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    end

    // Port-level checks.
    always_comb begin
        // R1
        sum_value_chk: assert (sum == total[WIDTH-1:0])
            else $error("sum %h expected %h", sum, total[WIDTH-1:0]);
        // R2
        carry_out_chk: assert (carry_out == total[WIDTH])
            else $error("carry_out %b expected %b", carry_out, total[WIDTH]);
        // R3
        cin_only_chk: assert (!((op_a == '0) && (op_b == '0)) ||
                              (sum == WIDTH'(carry_in) && !carry_out))
            else $error("zero operands gave %h/%b", sum, carry_out);
    end

    for (genvar g = 1; g < NGRP; g++) begin : g_chain
        logic [GRP:0] slice_total;

        // Reference for this group alone, given the chain carry into it.
        always_comb begin
            slice_total = {1'b0, op_a[g*GRP +: GRP]} + {1'b0, op_b[g*GRP +: GRP]}
                        + {{GRP{1'b0}}, grp_carry[g]};
        end

        always_comb begin
            // R6
            group_carry_chk: assert (grp_carry[g+1] == slice_total[GRP])
                else $error("group %0d carry %b expected %b", g, grp_carry[g+1], slice_total[GRP]);
            // R6
            group_sum_chk: assert (sum[g*GRP +: GRP] == slice_total[GRP-1:0])
                else $error("group %0d sum %h expected %h", g, sum[g*GRP +: GRP], slice_total[GRP-1:0]);
        end
    end

endmodule

bind csa_bec_adder csa_bec_adder_chk #(.WIDTH(WIDTH), .GRP(GRP)) chk_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .grp_carry (grp_carry)
);

// File: tb/csa_bec_adder_tb_top.sv
// Bench for csa_bec_adder: one 16/4 copy and two small copies (8/4, 6/2),
// all checked against integer addition.
module csa_bec_adder_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   failures = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    // 16-bit default copy.
    logic [15:0] a16, b16, s16;
    logic        ci16, co16;
    csa_bec_adder #(.WIDTH(16), .GRP(4)) dut_i (
        .op_a(a16), .op_b(b16), .carry_in(ci16), .sum(s16), .carry_out(co16));

    // 8-bit copy with 4-bit groups.
    logic [7:0] a8, b8, s8;
    logic       ci8, co8;
    csa_bec_adder #(.WIDTH(8), .GRP(4)) small_i (
        .op_a(a8), .op_b(b8), .carry_in(ci8), .sum(s8), .carry_out(co8));

    // 6-bit copy with 2-bit groups.
    logic [5:0] a6, b6, s6;
    logic       ci6, co6;
    csa_bec_adder #(.WIDTH(6), .GRP(2)) tiny_i (
        .op_a(a6), .op_b(b6), .carry_in(ci6), .sum(s6), .carry_out(co6));

    // Compare one value, count it, report a mismatch.
    task automatic check(input string req, input string what,
                         input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive the 16-bit copy, then compare with integer addition.
    task automatic run16(input logic [15:0] a, input logic [15:0] b,
                         input logic ci, input string req);
        logic [16:0] t;
        a16 = a; b16 = b; ci16 = ci;
        #1;
        t = {1'b0, a} + {1'b0, b} + {16'd0, ci};
        check(req, "sum16",   {1'b0, s16}, {1'b0, t[15:0]});
        check(req, "carry16", {16'd0, co16}, {16'd0, t[16]});
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    logic [15:0] edges [12] = '{16'h0000, 16'h0001, 16'h000F, 16'h0010,
                                16'h00F0, 16'h00FF, 16'h0F00, 16'hF000,
                                16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};

    initial begin
        a16 = '0; b16 = '0; ci16 = 1'b0;
        a8 = '0;  b8 = '0;  ci8 = 1'b0;
        a6 = '0;  b6 = '0;  ci6 = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // Quiet state during reset: zero operands give zero outputs.
        check("R1", "reset sum",   {1'b0, s16}, 17'd0);
        check("R2", "reset carry", {16'd0, co16}, 17'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R3: carry-in alone enters the lowest group.
        a16 = 16'h0000; b16 = 16'h0000; ci16 = 1'b1;
        #1;
        check("R3", "cin only sum",   {1'b0, s16}, 17'h00001);
        check("R3", "cin only carry", {16'd0, co16}, 17'd0);
        #1;

        // R4: carry from the lowest group ripples through every group.
        a16 = 16'hFFFF; b16 = 16'h0001; ci16 = 1'b0;
        #1;
        check("R4", "full ripple sum",   {1'b0, s16}, 17'h00000);
        check("R4", "full ripple carry", {16'd0, co16}, 17'd1);
        #1;

        // R5: carry-in alone ripples through every group.
        a16 = 16'hFFFF; b16 = 16'h0000; ci16 = 1'b1;
        #1;
        check("R5", "cin ripple sum",   {1'b0, s16}, 17'h00000);
        check("R5", "cin ripple carry", {16'd0, co16}, 17'd1);
        #1;

        // R6: an upper group wraps from all ones when the carry from below is set.
        a16 = 16'h00F8; b16 = 16'h0008; ci16 = 1'b0;
        #1;
        check("R6", "group wrap sum",   {1'b0, s16}, 17'h00100);
        check("R6", "group wrap carry", {16'd0, co16}, 17'd0);
        #1;
        // R6: the increment inside one group without wrapping.
        run16(16'h0038, 16'h0008, 1'b0, "R6");

        // R1 R2: all pairs of boundary patterns, both carry-in values.
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                for (int c = 0; c < 2; c++)
                    run16(edges[i], edges[j], c[0], "R1/R2 edge");

        // R1 R2: random operands.
        for (int n = 0; n < 3000; n++)
            run16(16'($urandom), 16'($urandom), 1'($urandom), "R1/R2 random");

        // R7: exhaustive sweep of the 8-bit, 4-bit-group copy.
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                for (int c = 0; c < 2; c++) begin
                    logic [8:0] t8;
                    a8 = 8'(a); b8 = 8'(b); ci8 = c[0];
                    #1;
                    t8 = 9'(a + b + c);
                    check("R7", "8/4 total", {8'd0, co8, s8}, {8'd0, t8});
                    #1;
                end

        // R7: exhaustive sweep of the 6-bit, 2-bit-group copy.
        for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++)
                for (int c = 0; c < 2; c++) begin
                    logic [6:0] t6;
                    a6 = 6'(a); b6 = 6'(b); ci6 = c[0];
                    #1;
                    t6 = 7'(a + b + c);
                    check("R7", "6/2 total", {10'd0, co6, s6}, {10'd0, t6});
                    #1;
                end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule